// File: doc/BRIEF.md
# Serial Clock Rate Generator

This block turns the system clock into the timing skeleton of a two-wire serial bus master. Two small divisor values, a 2-bit value A and a 6-bit value B, set a cascaded prescaler that emits one enable tick every (A+1)·(B+1) system clocks. A phase counter then walks through 22 ticks per serial clock period: 11 ticks with the serial clock low, followed by 11 ticks with it high. So the serial clock rate is the input clock divided by 22·(A+1)·(B+1), and it can never exceed the input clock divided by 22.

Beside the serial clock level, the block gives two single-cycle strobes. One marks the point in the low half where a master should change its data line. The other marks the point in the high half where it should sample the data line. A protocol engine uses these strobes as its only timing reference.

Divisor values are meant to be changed only while the block is idle. If they do change during a run, the new values are taken only at the next period boundary, so a period is never cut short. While the enable input is low, the serial clock stays high and no strobes are produced.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, scl_o is 1 and drive_stb_o and sample_stb_o are 0.
- R2: While enabled, successive falling edges of scl_o are exactly 22·N system clocks apart, where N = (div_a_i+1)·(div_b_i+1). div_a_i ranges 0..3 and div_b_i ranges 0..63.
- R3: Within each period, scl_o is low for 11·N clocks and then high for 11·N clocks.
- R4: drive_stb_o pulses high for one clock exactly once per low half, 5·N clocks after the clock on which scl_o fell. It never pulses while scl_o is high.
- R5: sample_stb_o pulses high for one clock exactly once per high half, 5·N clocks after the clock on which scl_o rose. It never pulses while scl_o is low.
- R6: With div_a_i = 0 and div_b_i = 0, the period is 22 clocks, which is the fastest rate.
- R7: A divisor change made partway through a period leaves that period's length unchanged. The values present at the clock edge that ends the period govern the next period, including a change that arrives in the last cycle of the period.
- R8: While enable_i is low, scl_o is 1 and both strobes are 0, starting at the first clock edge that sees enable_i low.
- R9: scl_o falls at the first clock edge that sees enable_i high. The divisor values present at that edge govern the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the generator when high; idles it when low |
| div_a_i | input | 2 | Prescaler value A, factor A+1 |
| div_b_i | input | 6 | Divisor value B, factor B+1 |
| scl_o | output | 1 | Serial clock level |
| drive_stb_o | output | 1 | One-cycle strobe to change the data line (mid low half) |
| sample_stb_o | output | 1 | One-cycle strobe to sample the data line (mid high half) |

## Verification
Two functions can land in the same cycle: the period-boundary reload of the effective divisors, and a change on the divisor inputs. The bench provokes this by changing div_a_i and div_b_i at a chosen offset inside a running period. The offsets include the first cycle after the falling edge and the very last cycle before the next falling edge, plus random offsets in between. It then judges the result by measuring the period in progress, which must keep the old length, and the following period, which must use the new length in full.

// File: rtl/sg_pkg.sv
package sg_pkg;

    parameter int unsigned SG_A_W    = 2;
    parameter int unsigned SG_B_W    = 6;
    parameter int unsigned SG_PERIOD = 22;

    // tick index (within one period) at which the data-change strobe fires
    function automatic int unsigned drive_slot(int unsigned period);
        return period / 4;
    endfunction

    // tick index at which the data-sample strobe fires (middle of high half)
    function automatic int unsigned sample_slot(int unsigned period);
        return period / 2 + period / 4;
    endfunction

endpackage

// File: rtl/sg_prescaler.sv
module sg_prescaler #(
    parameter int unsigned A_W = sg_pkg::SG_A_W,
    parameter int unsigned B_W = sg_pkg::SG_B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [A_W-1:0] div_a_i,
    input  logic [B_W-1:0] div_b_i,
    input  logic           reload_i,
    output logic           tick_o
);

    typedef struct packed {
        logic           run;
        logic [A_W-1:0] cnt_a;
        logic [B_W-1:0] cnt_b;
        logic [A_W-1:0] a_eff;
        logic [B_W-1:0] b_eff;
    } pre_t;

    pre_t pre_d, pre_q;
    logic wrap_a, wrap_b;

    always_comb begin
        wrap_a = (pre_q.cnt_a == pre_q.a_eff);
        wrap_b = (pre_q.cnt_b == pre_q.b_eff);
        tick_o = pre_q.run && wrap_a && wrap_b;
        pre_d  = pre_q;
        if (!en_i) begin
            pre_d = '0;
        end else if (!pre_q.run) begin
            pre_d.run   = 1'b1;
            pre_d.cnt_a = '0;
            pre_d.cnt_b = '0;
            pre_d.a_eff = div_a_i;
            pre_d.b_eff = div_b_i;
        end else begin
            if (wrap_a) begin
                pre_d.cnt_a = '0;
                pre_d.cnt_b = wrap_b ? '0 : pre_q.cnt_b + 1'b1;
            end else begin
                pre_d.cnt_a = pre_q.cnt_a + 1'b1;
            end
            if (reload_i) begin
                pre_d.a_eff = div_a_i;
                pre_d.b_eff = div_b_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: the second stage never runs past its effective limit
    p_cnt_b_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.cnt_b <= pre_q.b_eff);

    // R7: effective divisors move only at a period boundary while running
    p_eff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q.run && $past(pre_q.run) && !$past(reload_i))
        |-> ($stable(pre_q.a_eff) && $stable(pre_q.b_eff)));

endmodule

// File: rtl/sg_phase.sv
module sg_phase #(
    parameter int unsigned PERIOD = sg_pkg::SG_PERIOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic period_end_o,
    output logic scl_o,
    output logic drv_o,
    output logic smp_o
);

    localparam int unsigned PH_W = $clog2(PERIOD);
    localparam int unsigned HALF = PERIOD / 2;
    localparam int unsigned DRV  = sg_pkg::drive_slot(PERIOD);
    localparam int unsigned SMP  = sg_pkg::sample_slot(PERIOD);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            scl;
        logic            drv;
        logic            smp;
    } phs_t;

    phs_t phs_d, phs_q;

    always_comb begin
        period_end_o = en_i && tick_i && (phs_q.ph == PH_W'(PERIOD - 1));
        phs_d = phs_q;
        if (!en_i) begin
            phs_d.ph  = '0;
            phs_d.scl = 1'b1;
            phs_d.drv = 1'b0;
            phs_d.smp = 1'b0;
        end else begin
            if (tick_i)
                phs_d.ph = period_end_o ? '0 : phs_q.ph + 1'b1;
            phs_d.drv = tick_i && (phs_q.ph == PH_W'(DRV - 1));
            phs_d.smp = tick_i && (phs_q.ph == PH_W'(SMP - 1));
            phs_d.scl = (phs_d.ph >= PH_W'(HALF));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phs_q     <= '0;
            phs_q.scl <= 1'b1;
        end else begin
            phs_q <= phs_d;
        end
    end

    assign scl_o = phs_q.scl;
    assign drv_o = phs_q.drv;
    assign smp_o = phs_q.smp;

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phs_q.ph < PH_W'(PERIOD));

    p_drv_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phs_q.drv |-> !phs_q.scl);

    p_smp_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phs_q.smp |-> phs_q.scl);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (phs_q.scl && !phs_q.drv && !phs_q.smp));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int unsigned A_W    = sg_pkg::SG_A_W,
    parameter int unsigned B_W    = sg_pkg::SG_B_W,
    parameter int unsigned PERIOD = sg_pkg::SG_PERIOD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable_i,
    input  logic [A_W-1:0] div_a_i,
    input  logic [B_W-1:0] div_b_i,
    output logic           scl_o,
    output logic           drive_stb_o,
    output logic           sample_stb_o
);

    logic tick;
    logic period_end;

    sg_prescaler #(.A_W(A_W), .B_W(B_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .div_a_i  (div_a_i),
        .div_b_i  (div_b_i),
        .reload_i (period_end),
        .tick_o   (tick)
    );

    sg_phase #(.PERIOD(PERIOD)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (enable_i),
        .tick_i       (tick),
        .period_end_o (period_end),
        .scl_o        (scl_o),
        .drv_o        (drive_stb_o),
        .smp_o        (sample_stb_o)
    );

    // R4/R5: the two strobes never coincide
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_stb_o && sample_stb_o));

endmodule

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] da = '0;
    logic [5:0] db = '0;
    logic       scl, drv, smp;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    scl_rate_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (en),
        .div_a_i      (da),
        .div_b_i      (db),
        .scl_o        (scl),
        .drive_stb_o  (drv),
        .sample_stb_o (smp)
    );

    function automatic int exp_n(int a, int b);
        return (a + 1) * (b + 1);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the first negedge with scl low after a fall; returns at the
    // first negedge with scl low after the next fall. Optionally changes the
    // divisors when the in-period cycle count equals chg_at.
    task automatic measure(input int n, input int chg_at, input int na, input int nb);
        int lo = 0, hi = 0, doff = -1, soff = -1, dcnt = 0, scnt = 0, bad_pos = 0;
        while (scl == 1'b0) begin
            if (lo == chg_at) begin da = 2'(na); db = 6'(nb); end
            if (drv) begin dcnt++; if (doff < 0) doff = lo; end
            if (smp) bad_pos++;
            lo++;
            @(negedge clk);
        end
        while (scl == 1'b1) begin
            if (lo + hi == chg_at) begin da = 2'(na); db = 6'(nb); end
            if (smp) begin scnt++; if (soff < 0) soff = hi; end
            if (drv) bad_pos++;
            hi++;
            @(negedge clk);
        end
        chk(lo + hi == 22 * n, "R2 period", lo + hi, 22 * n);
        chk(lo == 11 * n && hi == 11 * n, "R3 low/high split", lo * 1000 + hi, 11 * n * 1001);
        chk(doff == 5 * n && dcnt == 1, "R4 drive strobe", doff * 100 + dcnt, 5 * n * 100 + 1);
        chk(soff == 5 * n && scnt == 1, "R5 sample strobe", soff * 100 + scnt, 5 * n * 100 + 1);
        chk(bad_pos == 0, "R4 R5 strobe in wrong half", bad_pos, 0);
        if (n == 1) chk(lo + hi == 22, "R6 fastest period", lo + hi, 22);
    endtask

    // Idle, load divisors while idle, enable, measure two periods.
    task automatic run_cfg(input int a, input int b);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        da = 2'(a); db = 6'(b);
        @(negedge clk);
        chk(scl && !drv && !smp, "R8 idle outputs", {scl, drv, smp}, 3'b100);
        en = 1'b1;
        @(negedge clk);
        chk(scl == 1'b0, "R9 fall on first enabled edge", scl, 0);
        measure(exp_n(a, b), -1, 0, 0);   // R9: divisors loaded while idle govern
        measure(exp_n(a, b), -1, 0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(scl && !drv && !smp, "R1 reset state", {scl, drv, smp}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl && !drv && !smp, "R1 after reset", {scl, drv, smp}, 3'b100);

        // directed corners
        run_cfg(0, 0);    // R6
        run_cfg(3, 0);
        run_cfg(0, 63);
        run_cfg(3, 63);

        // random configurations
        for (int i = 0; i < 20; i++) begin
            int a = int'($urandom % 4);
            int b = int'($urandom % 16);
            run_cfg(a, b);
        end

        // R7: mid-period divisor changes, including first and last cycles
        for (int i = 0; i < 8; i++) begin
            int a0 = int'($urandom % 4);
            int b0 = int'($urandom % 8);
            int a1 = int'($urandom % 4);
            int b1 = int'($urandom % 8);
            int n0 = exp_n(a0, b0);
            int k;
            if (i == 0)      k = 0;
            else if (i == 1) k = 22 * n0 - 1;
            else             k = int'($urandom % (22 * n0));
            run_cfg(a0, b0);
            measure(n0, k, a1, b1);            // R7 current period keeps old length
            measure(exp_n(a1, b1), -1, 0, 0);  // R7 next period uses new values
        end

        // R8: disable in the middle of a running period
        run_cfg(1, 3);
        repeat (int'($urandom % 40) + 3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            chk(scl && !drv && !smp, "R8 quiet after disable", {scl, drv, smp}, 3'b100);
            @(negedge clk);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule